// File: doc/BRIEF.md
# Half-precision to integer converter

This block turns IEEE 754 binary16 values into 16-bit integers, either signed or unsigned. A 7-bit function code selects the signedness and one of five rounding modes. The block raises an invalid flag and an inexact flag. The same conversion is applied to every active lane of a packed vector of 16-bit elements. A wide vector has eight lanes and a narrow vector has four. In scalar form only lane 0 is converted.

An operation is presented for one clock with `in_valid` high. The results and flags appear on the registered outputs one clock later, with `out_valid` high. Each lane result fills its own 16 bits with no sign extension. Lanes that are not active read as zero. Each flag is the OR of that flag over the active lanes. A function code outside the ten conversion codes is not converted. It is reported on `illegal_op`.

Top module: `hpcvt_simd`

## Requirements
- R1: Function codes 0x1a, 0x1b, 0x1c, 0x3a and 0x3b convert to a signed 16-bit integer. Their rounding modes are, in that order: nearest with ties to even, toward minus infinity, nearest with ties away from zero, toward plus infinity, and toward zero.
- R2: Function codes 0x5a, 0x5b, 0x5c, 0x7a and 0x7b convert to an unsigned 16-bit integer. They use the same five rounding modes in the same order.
- R3: A NaN lane (exponent field all ones and a nonzero fraction, quiet or signalling) gives 0 and raises invalid.
- R4: A rounded value outside the destination range saturates and raises invalid without inexact. Signed results clamp to -32768 or 32767, and unsigned results clamp to 65535. An infinity saturates to the limit of its own sign.
- R5: The inexact flag is raised when an in-range result differs from the exact input value.
- R6: In unsigned mode, a negative input that rounds to zero gives 0 without invalid. A negative input that rounds to -1 or below gives 0 and raises invalid.
- R7: In vector form, 8 lanes are converted when `wide_mode` is 1 and 4 lanes when it is 0. Lane i occupies bits [16i+15:16i], and the bits of inactive lanes are 0.
- R8: In scalar form, only lane 0 is converted and bits [127:16] of the result are 0.
- R9: An unrecognised function code raises `illegal_op` and gives an all-zero result with both flags clear.
- R10: The outputs are registered one cycle after `in_valid`. Reset clears `out_valid`, the result and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| func_code | input | 7 | Conversion function code |
| scalar_mode | input | 1 | 1: convert lane 0 only |
| wide_mode | input | 1 | Vector form: 1 = 8 lanes, 0 = 4 lanes |
| src_vec | input | 128 | Packed binary16 source lanes |
| out_valid | output | 1 | Result registered this cycle |
| dst_vec | output | 128 | Packed 16-bit integer results |
| flag_invalid | output | 1 | OR of invalid over the active lanes |
| flag_inexact | output | 1 | OR of inexact over the active lanes |
| illegal_op | output | 1 | Function code not recognised |

## Verification
The hardest cases to reach are exact ties and values just at the range limits under each rounding mode. Examples are 2.5 and -2.5, negative fractions in unsigned mode, and 32768 in signed mode. Uniform random bit patterns rarely land on these. The stimulus therefore drives directed lanes for each of them across all ten function codes. It adds random operands whose exponents are kept close to the integer range, mixed with fully random patterns that reach the NaN, infinity and subnormal encodings.

// File: rtl/hpcvt_pkg.sv
package hpcvt_pkg;

    localparam int ELEM_W = 16;
    localparam int FUNC_W = 7;

    typedef enum logic [2:0] {
        RND_NEAR_EVEN = 3'd0,
        RND_DOWN      = 3'd1,
        RND_NEAR_AWAY = 3'd2,
        RND_UP        = 3'd3,
        RND_ZERO      = 3'd4
    } rnd_mode_e;

    typedef struct packed {
        logic      legal;
        logic      to_signed;
        rnd_mode_e mode;
    } cvt_op_t;

    typedef struct packed {
        logic [ELEM_W-1:0] value;
        logic              invalid;
        logic              inexact;
    } lane_res_t;

    function automatic cvt_op_t decode_func(input logic [FUNC_W-1:0] f);
        cvt_op_t op;
        op.legal     = 1'b1;
        op.to_signed = ~f[6];
        case (f)
            7'h1a, 7'h5a: op.mode = RND_NEAR_EVEN;
            7'h1b, 7'h5b: op.mode = RND_DOWN;
            7'h1c, 7'h5c: op.mode = RND_NEAR_AWAY;
            7'h3a, 7'h7a: op.mode = RND_UP;
            7'h3b, 7'h7b: op.mode = RND_ZERO;
            default: begin
                op.legal = 1'b0;
                op.mode  = RND_ZERO;
            end
        endcase
        return op;
    endfunction

endpackage

// File: rtl/hpcvt_decode.sv
module hpcvt_decode
    import hpcvt_pkg::*;
(
    input  logic [FUNC_W-1:0] func_code,
    output cvt_op_t           op
);
    always_comb op = decode_func(func_code);

    // R1/R2: a legal code carries signedness in its top bit
    always_comb begin
        if (op.legal) begin
            assert_sign_decode_R1: assert (op.to_signed == (func_code[6] == 1'b0));
        end
    end
endmodule

// File: rtl/hpcvt_lane.sv
module hpcvt_lane
    import hpcvt_pkg::*;
#(
    parameter int FRAC_BITS = 24
) (
    input  logic [ELEM_W-1:0] operand,
    input  logic              to_signed,
    input  rnd_mode_e         mode,
    output lane_res_t         res
);
    localparam int SIG_W  = 11;
    localparam int WIDE_W = SIG_W + 30;
    localparam int INT_W  = WIDE_W - FRAC_BITS;

    logic              sgn, is_nan, is_inf;
    logic [4:0]        expo, shamt;
    logic [9:0]        mant;
    logic [SIG_W-1:0]  sig;
    logic [WIDE_W-1:0] wide;
    logic [INT_W-1:0]  ipart;
    logic [FRAC_BITS-1:0] frac;
    logic              rbit, sticky, lost, inc;
    logic [INT_W:0]    mag;

    always_comb begin
        sgn    = operand[15];
        expo   = operand[14:10];
        mant   = operand[9:0];
        is_nan = (expo == 5'h1f) && (mant != 10'd0);
        is_inf = (expo == 5'h1f) && (mant == 10'd0);
        sig    = {expo != 5'd0, mant};
        shamt  = (expo == 5'd0 || expo == 5'h1f) ? 5'd0 : expo - 5'd1;
        wide   = {{(WIDE_W-SIG_W){1'b0}}, sig} << shamt;
        ipart  = wide[WIDE_W-1:FRAC_BITS];
        frac   = wide[FRAC_BITS-1:0];
        rbit   = frac[FRAC_BITS-1];
        sticky = |frac[FRAC_BITS-2:0];
        lost   = |frac;
        case (mode)
            RND_NEAR_EVEN: inc = rbit & (sticky | ipart[0]);
            RND_DOWN:      inc = lost & sgn;
            RND_NEAR_AWAY: inc = rbit;
            RND_UP:        inc = lost & ~sgn;
            default:       inc = 1'b0;
        endcase
        mag = {1'b0, ipart} + {{INT_W{1'b0}}, inc};

        res = '{value: '0, invalid: 1'b0, inexact: 1'b0};
        if (is_nan) begin
            res.invalid = 1'b1;
        end else if (to_signed) begin
            if (is_inf || (sgn && mag > 18'd32768) || (!sgn && mag > 18'd32767)) begin
                res.value   = sgn ? 16'h8000 : 16'h7fff;
                res.invalid = 1'b1;
            end else begin
                res.value   = sgn ? 16'(16'd0 - mag[15:0]) : mag[15:0];
                res.inexact = lost;
            end
        end else begin
            if (sgn) begin
                if (is_inf || mag != '0) begin
                    res.invalid = 1'b1;
                end else begin
                    res.inexact = lost;
                end
            end else if (is_inf || mag > 18'd65535) begin
                res.value   = 16'hffff;
                res.invalid = 1'b1;
            end else begin
                res.value   = mag[15:0];
                res.inexact = lost;
            end
        end
    end

    always_comb begin
        assert_sat_not_inexact_R4: assert (!(res.invalid && res.inexact));
        if (is_nan) begin
            assert_nan_zero_R3: assert (res.value == '0 && res.invalid);
        end
        if (!to_signed && sgn && !is_nan) begin
            assert_neg_unsigned_zero_R6: assert (res.value == '0);
        end
    end
endmodule

// File: rtl/hpcvt_simd.sv
module hpcvt_simd
    import hpcvt_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [6:0]              func_code,
    input  logic                    scalar_mode,
    input  logic                    wide_mode,
    input  logic [LANES*16-1:0]     src_vec,
    output logic                    out_valid,
    output logic [LANES*16-1:0]     dst_vec,
    output logic                    flag_invalid,
    output logic                    flag_inexact,
    output logic                    illegal_op
);
    localparam int VEC_W  = LANES * ELEM_W;
    localparam int NARROW = LANES / 2;

    cvt_op_t          op;
    lane_res_t        lane_res [LANES];
    logic [LANES-1:0] active;
    logic [VEC_W-1:0] dst_d;
    logic             inv_d, inx_d;

    hpcvt_decode u_decode (
        .func_code (func_code),
        .op        (op)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            hpcvt_lane u_lane (
                .operand   (src_vec[i*ELEM_W +: ELEM_W]),
                .to_signed (op.to_signed),
                .mode      (op.mode),
                .res       (lane_res[i])
            );
            assign active[i] = op.legal &&
                (scalar_mode ? (i == 0) : (wide_mode ? 1'b1 : (i < NARROW)));
        end
    endgenerate

    always_comb begin
        dst_d = '0;
        inv_d = 1'b0;
        inx_d = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (active[i]) begin
                dst_d[i*ELEM_W +: ELEM_W] = lane_res[i].value;
                inv_d = inv_d | lane_res[i].invalid;
                inx_d = inx_d | lane_res[i].inexact;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            dst_vec      <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            illegal_op   <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            dst_vec      <= in_valid ? dst_d : '0;
            flag_invalid <= in_valid & inv_d;
            flag_inexact <= in_valid & inx_d;
            illegal_op   <= in_valid & ~op.legal;
        end
    end

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && dst_vec == '0);
    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> dst_vec == '0 && !flag_invalid && !flag_inexact);
    assert_scalar_upper_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && scalar_mode |=> dst_vec[VEC_W-1:ELEM_W] == '0);
    assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && !scalar_mode && !wide_mode |=> dst_vec[VEC_W-1:VEC_W/2] == '0);
endmodule

// File: tb/test_hpcvt_simd.sv
`timescale 1ns/1ps
module test_hpcvt_simd;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [6:0]   func_code = 7'h1a;
    logic         scalar_mode = 1'b0;
    logic         wide_mode = 1'b1;
    logic [127:0] src_vec = '0;
    logic         out_valid, flag_invalid, flag_inexact, illegal_op;
    logic [127:0] dst_vec;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    hpcvt_simd i_hpcvt_simd (
        .clk, .rst, .in_valid, .func_code, .scalar_mode, .wide_mode, .src_vec,
        .out_valid, .dst_vec, .flag_invalid, .flag_inexact, .illegal_op
    );

    function automatic real h2r(input logic [15:0] h);
        real v;
        int e = int'(h[14:10]);
        int m = int'(h[9:0]);
        if (e == 0) v = real'(m) * (2.0 ** (-24));
        else        v = real'(1024 + m) * (2.0 ** (e - 25));
        return h[15] ? -v : v;
    endfunction

    function automatic logic [6:0] code_at(input int k);
        case (k)
            0: return 7'h1a; 1: return 7'h1b; 2: return 7'h1c; 3: return 7'h3a;
            4: return 7'h3b; 5: return 7'h5a; 6: return 7'h5b; 7: return 7'h5c;
            8: return 7'h7a; default: return 7'h7b;
        endcase
    endfunction

    // reference: returns {inv, inx, value}
    function automatic logic [17:0] ref_lane(input logic [6:0] f, input logic [15:0] h);
        bit sgnd = (f[6] == 1'b0);
        int mi;
        real x, ax, fl, d;
        longint r;
        logic [15:0] val;
        if (h[14:10] == 5'h1f) begin
            if (h[9:0] != 0) return {2'b10, 16'h0000};
            if (sgnd) return {2'b10, h[15] ? 16'h8000 : 16'h7fff};
            return {2'b10, h[15] ? 16'h0000 : 16'hffff};
        end
        x  = h2r(h);
        ax = (x < 0.0) ? -x : x;
        mi = int'(f[5:0]);
        case (mi)
            6'h1a: begin
                fl = $floor(x); d = x - fl;
                if (d > 0.5) r = longint'($rtoi(fl)) + 1;
                else if (d < 0.5) r = longint'($rtoi(fl));
                else r = longint'($rtoi(fl)) + ((($rtoi(fl) % 2) != 0) ? 1 : 0);
            end
            6'h1b: r = longint'($rtoi($floor(x)));
            6'h1c: begin
                r = longint'($rtoi($floor(ax + 0.5)));
                if (x < 0.0) r = -r;
            end
            6'h3a: r = longint'($rtoi($ceil(x)));
            default: begin
                r = longint'($rtoi($floor(ax)));
                if (x < 0.0) r = -r;
            end
        endcase
        if (sgnd) begin
            if (r < -32768) return {2'b10, 16'h8000};
            if (r > 32767)  return {2'b10, 16'h7fff};
        end else begin
            if (r < 0)      return {2'b10, 16'h0000};
            if (r > 65535)  return {2'b10, 16'hffff};
        end
        val = 16'(r);
        return {1'b0, (real'(r) != x), val};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [6:0] f, input bit sc,
                          input bit wd, input logic [127:0] src);
        logic [127:0] e_dst = '0;
        bit e_inv = 0, e_inx = 0, legal = 0;
        int n;
        logic [17:0] lr;
        for (int k = 0; k < 10; k++) if (code_at(k) == f) legal = 1;
        n = sc ? 1 : (wd ? 8 : 4);
        if (legal) begin
            for (int i = 0; i < n; i++) begin
                lr = ref_lane(f, src[i*16 +: 16]);
                e_dst[i*16 +: 16] = lr[15:0];
                e_inv |= lr[17];
                e_inx |= lr[16];
            end
        end
        @(negedge clk);
        func_code = f; scalar_mode = sc; wide_mode = wd; src_vec = src; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "result", dst_vec, e_dst);
        check(req, "flags", {124'b0, out_valid, flag_invalid, flag_inexact, illegal_op},
              {124'b0, 1'b1, e_inv, e_inx, !legal});
    endtask

    function automatic logic [127:0] splat(input logic [15:0] h);
        return {8{h}};
    endfunction

    function automatic logic [15:0] rand_half();
        logic [15:0] h = 16'($urandom);
        if ($urandom % 3 != 0) h[14:10] = 5'(10 + $urandom % 20);
        return h;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10", "reset state",
              {out_valid, flag_invalid, flag_inexact, illegal_op, dst_vec[123:0]}, '0);

        // R1/R2/R5: ties and fractions across all modes
        for (int k = 0; k < 10; k++) begin
            run_op(k < 5 ? "R1" : "R2", code_at(k), 0, 1,
                   {16'h4100, 16'hC100, 16'h3800, 16'hB800,
                    16'h3E00, 16'hBE00, 16'h4500, 16'h0001});
        end
        // R3: NaN lanes, quiet and signalling
        run_op("R3", 7'h1a, 0, 1, {4{16'h7E00, 16'h7C01}});
        run_op("R3", 7'h7b, 1, 0, {112'b0, 16'hFE00});
        // R4: saturation and infinities
        run_op("R4", 7'h3b, 0, 1, {16'h7800, 16'hF800, 16'h7C00, 16'hFC00,
                                   16'h7BFF, 16'hFBFF, 16'hF802, 16'h77FF});
        run_op("R4", 7'h5a, 0, 1, {16'h7800, 16'hF800, 16'h7C00, 16'hFC00,
                                   16'h7BFF, 16'h7BFE, 16'h3C00, 16'h0000});
        // R6: negative inputs in unsigned mode
        for (int k = 5; k < 10; k++)
            run_op("R6", code_at(k), 0, 1, {16'hB666, 16'hBC00, 16'hB800, 16'h8001,
                                            16'h8000, 16'hBA00, 16'hC000, 16'hB400});
        // R7: narrow vector clears the upper half
        run_op("R7", 7'h1c, 0, 0, splat(16'h4900));
        // R8: scalar form converts lane 0 only
        run_op("R8", 7'h5c, 1, 1, splat(16'h4900));
        // R9: illegal codes
        run_op("R9", 7'h1d, 0, 1, splat(16'h4900));
        run_op("R9", 7'h00, 1, 0, splat(16'h7E00));
        // R10: idle cycle after an operation
        @(negedge clk);
        check("R10", "idle", {dst_vec, out_valid}, '0);

        // random mix
        for (int t = 0; t < 400; t++) begin
            logic [127:0] s;
            logic [6:0] f;
            for (int i = 0; i < 8; i++) s[i*16 +: 16] = rand_half();
            f = ($urandom % 20 == 0) ? 7'($urandom) : code_at(int'($urandom % 10));
            run_op(f[6] ? "R2" : "R1", f, ($urandom % 4) == 0, $urandom % 2 == 1, s);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL R10 watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule